// File: doc/BRIEF.md
# Framed Serial Link Receiver

This block receives frames from a source-synchronous serial link that carries a clock wire and a data wire. Both wires are brought into the system clock domain through synchronizer flops. Each rising edge of the link clock yields one received bit. After a power-on reset or a soft reset, the receiver waits in a synchronising state and discards all traffic until it sees a flush: a long run of high bits closed by a single low bit. It then hunts for a start-of-frame pattern. A frame is read field by field, with a check on each field. A valid frame is handed out as a single-cycle strobe that carries the decoded fields.

Any fault (an illegal type code, a CRC mismatch, or a timeout on either watchdog) raises a sticky flag of its own and the sticky core error bit, and it parks the receiver in an error state. The frame watchdog limits how long one frame may take. The ping watchdog limits the gap between valid frames. Together they catch a receiver hung by clock edges that carry no useful data. The only ways out of the error state are a soft reset followed by a fresh flush, or the asynchronous reset.

Top module: `framed_link_rx`

## Requirements
- R1: After `rst_n` or `soft_rst`, the receiver ignores all bits until it samples at least 16 consecutive high bits followed by one low bit. A shorter high run followed by a low bit restarts the count. Frames sent before a qualifying flush produce no `frame_done`.
- R2: Once synchronised, the receiver detects the start of a frame on the bit sequence 1,0,0,1. It then reads, MSB first, a 4-bit type, a 4-bit tag, zero to two 16-bit data words, and an 8-bit CRC.
- R3: Type 1 is a ping with no data, type 2 carries one word, and type 3 carries two words. Any other type code sets `type_err` and `core_err` and enters the error state.
- R4: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, run over the tag bits and then the data bits. On a mismatch, `crc_err` and `core_err` are set, the error state is entered and no `frame_done` is produced.
- R5: A valid frame gives a one-cycle `frame_done` with `rx_type` and `rx_tag`. The first word received appears on `rx_word0` and the second on `rx_word1`. Missing words read as zero.
- R6: Flush sequences of any length that arrive while the receiver is synchronised and idle raise no flag, and a following frame is received normally.
- R7: When `frame_wd_en` is set and one frame stays in progress for `frame_period` system clock cycles, `frame_to` and `core_err` are set and the error state is entered.
- R8: When `ping_wd_en` is set and `ping_period` system clock cycles pass after synchronisation or after the last valid frame (pings included) without a new valid frame, `ping_to` and `core_err` are set.
- R9: `core_err` is 1 whenever any error flag is 1. All flags are sticky. In the error state no further frame is accepted.
- R10: A soft reset clears every flag and returns the receiver to the synchronising state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| link_clk | input | 1 | Link clock wire (asynchronous) |
| link_dat | input | 1 | Link data wire (asynchronous) |
| ping_wd_en | input | 1 | Enables the ping watchdog |
| ping_period | input | 16 | Ping watchdog limit in system clocks |
| frame_wd_en | input | 1 | Enables the frame watchdog |
| frame_period | input | 16 | Frame watchdog limit in system clocks |
| frame_done | output | 1 | One-cycle strobe for a valid frame |
| rx_type | output | 4 | Type of the last valid frame |
| rx_tag | output | 4 | Tag of the last valid frame |
| rx_word0 | output | 16 | First data word |
| rx_word1 | output | 16 | Second data word |
| type_err | output | 1 | Sticky illegal-type flag |
| crc_err | output | 1 | Sticky CRC mismatch flag |
| ping_to | output | 1 | Sticky ping watchdog timeout |
| frame_to | output | 1 | Sticky frame watchdog timeout |
| core_err | output | 1 | Sticky core error status |

## Verification
A wrong hunt or field-count state appears at the ports as a missing `frame_done`, or as shifted tag or data bits. It also causes a CRC error within one frame time of the fault. If the receiver leaves synchronisation too early, a frame sent before the flush is accepted. A stuck state shows up through the watchdog flags within one programmed period. A flag that fails to hold, or that survives a soft reset, is visible on the next sample.

// File: rtl/framed_link_rx.sv
module framed_link_rx #(
  parameter int WORD_W      = 16,
  parameter int TAG_W       = 4,
  parameter int FLUSH_MIN   = 16,
  parameter int WD_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              link_clk,
  input  logic              link_dat,
  input  logic              ping_wd_en,
  input  logic [WD_W-1:0]   ping_period,
  input  logic              frame_wd_en,
  input  logic [WD_W-1:0]   frame_period,
  output logic              frame_done,
  output logic [3:0]        rx_type,
  output logic [TAG_W-1:0]  rx_tag,
  output logic [WORD_W-1:0] rx_word0,
  output logic [WORD_W-1:0] rx_word1,
  output logic              type_err,
  output logic              crc_err,
  output logic              ping_to,
  output logic              frame_to,
  output logic              core_err
);
  localparam int DMAX = 2 * WORD_W;
  localparam int CW   = $clog2(DMAX + 1);
  localparam int OW   = $clog2(FLUSH_MIN + 1);
  localparam logic [3:0] T_PING = 4'd1, T_ONE = 4'd2, T_TWO = 4'd3;

  typedef enum logic [2:0] {S_SYNC, S_IDLE, S_TYPE, S_TAG, S_DATA, S_CRC, S_ERR} st_t;
  st_t st;

  logic [SYNC_STAGES:0]   ck_sr;
  logic [SYNC_STAGES-1:0] dt_sr;
  logic [OW-1:0]          ones;
  logic [3:0]             hunt, typ;
  logic [TAG_W-1:0]       tag;
  logic [DMAX-1:0]        dsr;
  logic [7:0]             crc, crx;
  logic [CW-1:0]          cnt;
  logic [WD_W-1:0]        fwd, pwd;

  wire bv  = ck_sr[SYNC_STAGES-1] & ~ck_sr[SYNC_STAGES];
  wire bit_in = dt_sr[SYNC_STAGES-1];
  wire in_frame = (st == S_TYPE) || (st == S_TAG) || (st == S_DATA) || (st == S_CRC);
  wire live = in_frame || (st == S_IDLE);
  wire [CW-1:0] dlast = (typ == T_TWO) ? CW'(DMAX - 1) : CW'(WORD_W - 1);
  wire [3:0] typ_n = {typ[2:0], bit_in};
  wire [7:0] crc_n = {crc[6:0], 1'b0} ^ ((crc[7] ^ bit_in) ? 8'h07 : 8'h00);
  wire f_hit = frame_wd_en && in_frame && ({1'b0, fwd} + 1'b1 >= {1'b0, frame_period});
  wire p_hit = ping_wd_en && live && ({1'b0, pwd} + 1'b1 >= {1'b0, ping_period});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sr <= '0;
      dt_sr <= '0;
    end else begin
      ck_sr <= {ck_sr[SYNC_STAGES-1:0], link_clk};
      dt_sr <= {dt_sr[SYNC_STAGES-2:0], link_dat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SYNC; ones <= '0; hunt <= '0; typ <= '0; tag <= '0; dsr <= '0;
      crc <= '0; crx <= '0; cnt <= '0; fwd <= '0; pwd <= '0;
      frame_done <= 1'b0; rx_type <= '0; rx_tag <= '0; rx_word0 <= '0; rx_word1 <= '0;
      type_err <= 1'b0; crc_err <= 1'b0; ping_to <= 1'b0; frame_to <= 1'b0; core_err <= 1'b0;
    end else if (soft_rst) begin
      st <= S_SYNC; ones <= '0; hunt <= '0; cnt <= '0; fwd <= '0; pwd <= '0;
      frame_done <= 1'b0;
      type_err <= 1'b0; crc_err <= 1'b0; ping_to <= 1'b0; frame_to <= 1'b0; core_err <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      fwd <= in_frame ? fwd + 1'b1 : '0;
      pwd <= !live ? '0 : (pwd == '1) ? pwd : pwd + 1'b1;
      if (bv) begin
        case (st)
          S_SYNC: begin
            if (bit_in) begin
              if (ones != OW'(FLUSH_MIN)) ones <= ones + 1'b1;
            end else begin
              if (ones == OW'(FLUSH_MIN)) begin
                st <= S_IDLE;
                hunt <= '0;
              end
              ones <= '0;
            end
          end
          S_IDLE: begin
            hunt <= {hunt[2:0], bit_in};
            if ({hunt[2:0], bit_in} == 4'b1001) begin
              st <= S_TYPE; cnt <= '0; crc <= '0;
            end
          end
          S_TYPE: begin
            typ <= typ_n;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(3)) begin
              cnt <= '0;
              if (typ_n == T_PING || typ_n == T_ONE || typ_n == T_TWO) st <= S_TAG;
              else begin
                type_err <= 1'b1; core_err <= 1'b1; st <= S_ERR;
              end
            end
          end
          S_TAG: begin
            tag <= {tag[TAG_W-2:0], bit_in};
            crc <= crc_n;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(TAG_W - 1)) begin
              cnt <= '0;
              st <= (typ == T_PING) ? S_CRC : S_DATA;
            end
          end
          S_DATA: begin
            dsr <= {dsr[DMAX-2:0], bit_in};
            crc <= crc_n;
            cnt <= cnt + 1'b1;
            if (cnt == dlast) begin
              cnt <= '0;
              st <= S_CRC;
            end
          end
          S_CRC: begin
            crx <= {crx[6:0], bit_in};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(7)) begin
              cnt <= '0;
              if ({crx[6:0], bit_in} == crc) begin
                frame_done <= 1'b1;
                rx_type <= typ;
                rx_tag <= tag;
                rx_word0 <= (typ == T_TWO) ? dsr[DMAX-1:WORD_W] : (typ == T_ONE) ? dsr[WORD_W-1:0] : '0;
                rx_word1 <= (typ == T_TWO) ? dsr[WORD_W-1:0] : '0;
                st <= S_IDLE;
                hunt <= '0;
                pwd <= '0;
              end else begin
                crc_err <= 1'b1; core_err <= 1'b1; st <= S_ERR;
              end
            end
          end
          default: ;
        endcase
      end
      if (f_hit) begin
        frame_to <= 1'b1; core_err <= 1'b1; st <= S_ERR; frame_done <= 1'b0;
      end
      if (p_hit && !(bv && st == S_CRC && cnt == CW'(7) && {crx[6:0], bit_in} == crc)) begin
        ping_to <= 1'b1; core_err <= 1'b1; st <= S_ERR; frame_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/framed_link_rx_checker.sv
module framed_link_rx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       frame_done,
  input logic [3:0] rx_type,
  input logic       type_err,
  input logic       crc_err,
  input logic       ping_to,
  input logic       frame_to,
  input logic       core_err
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> !frame_done); // R5
  AST_DONE_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) frame_done |-> (rx_type >= 4'd1 && rx_type <= 4'd3)); // R3
  AST_CORE_COVERS: assert property (@(posedge clk) disable iff (!rst_n) (type_err || crc_err || ping_to || frame_to) |-> core_err); // R9
  AST_CORE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (core_err && !soft_rst) |=> core_err); // R9
  AST_NO_DONE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n) core_err |-> !frame_done); // R9
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> !(core_err || type_err || crc_err || ping_to || frame_to)); // R10
endmodule

bind framed_link_rx framed_link_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .frame_done(frame_done), .rx_type(rx_type),
  .type_err(type_err), .crc_err(crc_err), .ping_to(ping_to), .frame_to(frame_to), .core_err(core_err)
);

// File: tb/framed_link_rx_test.sv
module framed_link_rx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, link_clk = 1'b0, link_dat = 1'b0;
  logic ping_wd_en = 1'b0, frame_wd_en = 1'b0;
  logic [15:0] ping_period = 16'd3000, frame_period = 16'd1000;
  logic frame_done, type_err, crc_err, ping_to, frame_to, core_err;
  logic [3:0] rx_type, rx_tag;
  logic [15:0] rx_word0, rx_word1;

  int checks = 0, errors = 0, cap_n = 0;
  logic [3:0] cap_type, cap_tag;
  logic [15:0] cap_w0, cap_w1;

  always #(CLK_PERIOD/2) clk = ~clk;

  framed_link_rx uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .link_clk(link_clk), .link_dat(link_dat),
    .ping_wd_en(ping_wd_en), .ping_period(ping_period), .frame_wd_en(frame_wd_en),
    .frame_period(frame_period), .frame_done(frame_done), .rx_type(rx_type), .rx_tag(rx_tag),
    .rx_word0(rx_word0), .rx_word1(rx_word1), .type_err(type_err), .crc_err(crc_err),
    .ping_to(ping_to), .frame_to(frame_to), .core_err(core_err)
  );

  always @(negedge clk) if (frame_done) begin
    cap_n++; cap_type = rx_type; cap_tag = rx_tag; cap_w0 = rx_word0; cap_w1 = rx_word1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [3:0] tag, input logic [31:0] d, input int nd);
    logic [7:0] c = 8'h00;
    logic b;
    for (int i = 3 + nd; i >= 0; i--) begin
      b = (i >= nd) ? tag[i - nd] : d[i];
      c = {c[6:0], 1'b0} ^ ((c[7] ^ b) ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk) link_dat = b;
    repeat (2) @(negedge clk);
    link_clk = 1'b1;
    repeat (3) @(negedge clk);
    link_clk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
    send_bit(1'b0);
  endtask

  task automatic send_frame(input logic [3:0] t, input logic [3:0] tag, input logic [15:0] w0,
                            input logic [15:0] w1, input logic [7:0] bad);
    logic [31:0] d;
    int nd;
    logic [7:0] c;
    nd = (t == 4'd3) ? 32 : (t == 4'd2) ? 16 : 0;
    d = (t == 4'd3) ? {w0, w1} : {16'h0, w0};
    c = crc8(tag, d, nd) ^ bad;
    send_bit(1); send_bit(0); send_bit(0); send_bit(1);
    for (int i = 3; i >= 0; i--) send_bit(t[i]);
    for (int i = 3; i >= 0; i--) send_bit(tag[i]);
    for (int i = nd - 1; i >= 0; i--) send_bit(d[i]);
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_soft;
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
  endtask

  task automatic frame_ok(input string req, input logic [3:0] t, input logic [3:0] tag,
                          input logic [15:0] w0, input logic [15:0] w1);
    int n0;
    n0 = cap_n;
    send_frame(t, tag, w0, w1, 8'h00);
    check(req, cap_n - n0, 1);
    check(req, {cap_type, cap_tag}, {t, tag});
    check(req, {cap_w0, cap_w1}, {(t == 4'd1) ? 16'h0 : w0, (t == 4'd3) ? w1 : 16'h0});
    check(req, core_err, 0);
  endtask

  initial begin
    int n0;
    logic [3:0] t;
    n0 = $urandom(32'd7331);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset flags", {frame_done, type_err, crc_err, ping_to, frame_to, core_err}, 0);

    send_frame(4'd2, 4'h5, 16'hBEEF, 16'h0, 8'h00);
    check("R1 no frame before flush", cap_n, 0);
    flush(10);
    send_frame(4'd2, 4'h5, 16'hBEEF, 16'h0, 8'h00);
    check("R1 short flush ignored", cap_n, 0);
    flush(16);
    frame_ok("R1 R2 R5 first frame", 4'd2, 4'hA, 16'h1234, 16'h0);

    flush(16); flush(40); flush(3);
    check("R6 flush in idle", {type_err, crc_err, core_err}, 0);
    frame_ok("R6 frame after flushes", 4'd3, 4'h3, 16'hCAFE, 16'h0F0F);
    frame_ok("R3 ping frame", 4'd1, 4'hF, 16'h0, 16'h0);

    ping_wd_en = 1'b1; frame_wd_en = 1'b1;
    for (int i = 0; i < 24; i++) begin
      t = 4'($urandom_range(1, 3));
      frame_ok("R4 R5 random frame", t, 4'($urandom), 16'($urandom), 16'($urandom));
    end

    repeat (2000) @(negedge clk);
    check("R8 no early ping timeout", ping_to, 0);
    repeat (1200) @(negedge clk);
    check("R8 ping timeout", {ping_to, core_err}, 2'b11);
    n0 = cap_n;
    send_frame(4'd2, 4'h1, 16'h1111, 16'h0, 8'h00);
    check("R9 no frame in error state", cap_n - n0, 0);

    do_soft;
    check("R10 soft reset clears", {type_err, crc_err, ping_to, frame_to, core_err}, 0);
    ping_wd_en = 1'b0;
    send_frame(4'd2, 4'h2, 16'h2222, 16'h0, 8'h00);
    check("R10 sync after soft reset", cap_n - n0, 0);
    flush(16);
    frame_ok("R10 frame after resync", 4'd2, 4'h6, 16'h7777, 16'h0);

    n0 = cap_n;
    send_frame(4'd3, 4'h9, 16'hA5A5, 16'h5A5A, 8'h10);
    check("R4 crc error", {crc_err, core_err, type_err}, 3'b110);
    check("R4 no done on bad crc", cap_n - n0, 0);
    repeat (500) @(negedge clk);
    check("R9 crc flag sticky", {crc_err, core_err}, 2'b11);

    do_soft; flush(20);
    send_frame(4'd7, 4'h1, 16'h0, 16'h0, 8'h00);
    check("R3 type error code 7", {type_err, core_err, crc_err}, 3'b110);
    do_soft; flush(20);
    send_frame(4'd0, 4'h1, 16'h0, 16'h0, 8'h00);
    check("R3 type error code 0", {type_err, core_err}, 2'b11);

    do_soft; flush(20);
    send_bit(1); send_bit(0); send_bit(0); send_bit(1);
    send_bit(0); send_bit(0); send_bit(1); send_bit(0);
    repeat (500) @(negedge clk);
    check("R7 no early frame timeout", frame_to, 0);
    repeat (600) @(negedge clk);
    check("R7 frame timeout", {frame_to, core_err, ping_to}, 3'b110);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule